// File: doc/BRIEF.md
# Single-Wire Bus Slot Master

This block is the bit-level master for an open-drain single-wire bus held high by a pullup resistor. A host hands it one request at a time. A request is a bus reset with a presence check, a single written bit, or a single read bit. The block pulls the line low through an active-low drive enable and samples the line through a two-stage synchronizer. It reports the outcome with a one-cycle completion strobe. Byte assembly and command sequencing sit above it; the host sends bytes one bit at a time, least-significant bit first.

All timing counts microseconds. A cycle prescaler sized by `CLK_PER_US` produces the microsecond tick, and it restarts on every accepted request so each slot starts cleanly. The high-side cost of each slot is fixed. A write-1 or a read pulls low briefly, and a write-0 holds low for the whole slot. A read samples late in the valid window. Any request may also carry a strong-pullup hold length. After the slot, the block asserts a strong-pullup enable for that many microseconds. During that time the bus stays quiet.

Top module: `owm_slot_master`

## Requirements
- R1: After reset, `busy` and `done` are 0, `line_drive_n` is 1 (line released) and `spu_en` is 0.
- R2: Op code 2'b00 (bus reset) pulls the line low for 480 µs, then releases it for another 480 µs. The line is sampled 70 µs after release, and `result` is 1 (presence) if it was low there and 0 otherwise.
- R3: Op code 2'b01 with `req_bit`=1 (write-1) pulls the line low for 6 µs, then releases it.
- R4: Op code 2'b01 with `req_bit`=0 (write-0) pulls the line low for the full 65 µs slot. Every write or read slot lasts 65 µs plus 2 µs of released recovery.
- R5: Op code 2'b10 (read) pulls the line low for 6 µs. `result` is the line level sampled at 13 µs after the falling edge. A write leaves `result` at 0.
- R6: `busy` rises the cycle after a request is accepted and stays high up to and including the single `done` cycle. It falls the next cycle. `result` is valid from `done` until the next acceptance.
- R7: A request presented while `busy` is high is ignored. It changes neither the running slot's line timing, nor its length, nor its result.
- R8: When `req_spu_us` is nonzero at acceptance, `spu_en` rises at the end of the recovery period, 2 µs after the 65 µs slot and well within 10 µs. It stays high for exactly `req_spu_us` µs, and `done` follows. A value of zero gives no strong pullup. The line is never pulled low while `spu_en` is high.
- R9: Every duration equals its microsecond count times `CLK_PER_US` clock cycles, measured from the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_op | input | 2 | 00 bus reset, 01 write bit, 10 or 11 read bit |
| req_bit | input | 1 | Bit value for a write |
| req_spu_us | input | SPU_W | Strong-pullup hold in µs after the slot, 0 for none |
| line_in | input | 1 | Bus level as seen at the pad |
| line_drive_n | output | 1 | 0 pulls the bus low, 1 releases it |
| spu_en | output | 1 | Strong-pullup enable |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 1 | Presence flag after a reset, read bit after a read |

## Verification
A wrong microsecond count or a slip in the prescaler shows at the pins within the first slot. The line's low time, the slot length seen on `busy`, and the start of `spu_en` all land a whole number of `CLK_PER_US` cycles off. An op or bit latched wrongly, or a late request that leaks in, shows up as a low pulse of the wrong class (6, 65 or 480 µs). A bad sample point shows up as a wrong `result` at the very next `done`. The bench models a responding device, so a misplaced sample reads the released level instead of the answer.

// File: rtl/owm_pkg.sv
package owm_pkg;

    typedef enum logic [1:0] {
        OP_RESET = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_READX = 2'b11
    } owm_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SLOT,
        ST_SPU,
        ST_DONE
    } owm_state_e;

endpackage

// File: rtl/owm_tick_gen.sv
module owm_tick_gen #(
    parameter int CLK_PER_US = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == LAST);
        cnt_d = cnt_q;
        if (clr || tick) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/owm_sync.sv
module owm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d;
        for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/owm_slot_master.sv
module owm_slot_master
    import owm_pkg::*;
#(
    parameter int CLK_PER_US  = 50,
    parameter int SPU_W       = 16,
    parameter int RST_LOW_US  = 480,
    parameter int RST_WAIT_US = 480,
    parameter int PRES_AT_US  = 70,
    parameter int SLOT_US     = 65,
    parameter int SHORT_US    = 6,
    parameter int SAMPLE_AT_US = 13,
    parameter int RECOV_US    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic             req_bit,
    input  logic [SPU_W-1:0] req_spu_us,
    input  logic             line_in,
    output logic             line_drive_n,
    output logic             spu_en,
    output logic             busy,
    output logic             done,
    output logic             result
);
    localparam int RST_TOTAL = RST_LOW_US + RST_WAIT_US;
    localparam int TW        = $clog2(RST_TOTAL + 1);
    localparam int US_W      = (TW > SPU_W) ? TW : SPU_W;

    localparam logic [US_W-1:0] RST_LOW  = US_W'(RST_LOW_US);
    localparam logic [US_W-1:0] RST_END  = US_W'(RST_TOTAL);
    localparam logic [US_W-1:0] RST_SMP  = US_W'(RST_LOW_US + PRES_AT_US);
    localparam logic [US_W-1:0] BIT_LONG = US_W'(SLOT_US);
    localparam logic [US_W-1:0] BIT_SHRT = US_W'(SHORT_US);
    localparam logic [US_W-1:0] BIT_END  = US_W'(SLOT_US + RECOV_US);
    localparam logic [US_W-1:0] BIT_SMP  = US_W'(SAMPLE_AT_US);

    typedef struct packed {
        owm_state_e       state;
        owm_op_e          op;
        logic             wbit;
        logic [SPU_W-1:0] spu_len;
        logic [US_W-1:0]  us;
        logic             res;
    } regs_t;

    regs_t r_d, r_q;
    logic  tick;
    logic  line_s;
    logic [US_W-1:0] low_len, end_len, smp_pt;

    owm_tick_gen #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (r_q.state == ST_IDLE),
        .tick (tick)
    );

    owm_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (line_in),
        .q    (line_s)
    );

    // slot shape per operation
    always_comb begin
        case (r_q.op)
            OP_RESET: begin
                low_len = RST_LOW;
                end_len = RST_END;
                smp_pt  = RST_SMP;
            end
            OP_WRITE: begin
                low_len = r_q.wbit ? BIT_SHRT : BIT_LONG;
                end_len = BIT_END;
                smp_pt  = BIT_SMP;
            end
            default: begin
                low_len = BIT_SHRT;
                end_len = BIT_END;
                smp_pt  = BIT_SMP;
            end
        endcase
    end

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.state   = ST_SLOT;
                    r_d.op      = owm_op_e'(req_op);
                    r_d.wbit    = req_bit;
                    r_d.spu_len = req_spu_us;
                    r_d.us      = '0;
                    r_d.res     = 1'b0;
                end
            end
            ST_SLOT: begin
                if (tick) begin
                    r_d.us = r_q.us + 1'b1;
                    if (r_q.us == smp_pt) begin
                        if (r_q.op == OP_RESET)      r_d.res = ~line_s;
                        else if (r_q.op != OP_WRITE) r_d.res = line_s;
                    end
                    if (r_q.us == end_len - 1'b1) begin
                        r_d.us    = '0;
                        r_d.state = (r_q.spu_len != '0) ? ST_SPU : ST_DONE;
                    end
                end
            end
            ST_SPU: begin
                if (tick) begin
                    r_d.us = r_q.us + 1'b1;
                    if (r_q.us == US_W'(r_q.spu_len) - 1'b1) r_d.state = ST_DONE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= ST_IDLE;
            r_q.op      <= OP_RESET;
            r_q.wbit    <= 1'b0;
            r_q.spu_len <= '0;
            r_q.us      <= '0;
            r_q.res     <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign line_drive_n = ~((r_q.state == ST_SLOT) && (r_q.us < low_len));
    assign spu_en       = (r_q.state == ST_SPU);
    assign busy         = (r_q.state != ST_IDLE);
    assign done         = (r_q.state == ST_DONE);
    assign result       = r_q.res;

    // R8: no pull-down while the strong pullup is on
    a_r8_quiet_under_spu: assert property (@(posedge clk) disable iff (!rst_n)
        spu_en |-> line_drive_n);

    // R8: strong pullup phase ends straight into completion
    a_r8_spu_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spu_en) |-> done);

    // R6: completion is followed by idle
    a_r6_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R6: an idle request is taken on the next edge
    a_r6_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    // R2: the line is only driven inside a request
    a_r2_drive_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !line_drive_n |-> busy);

    // R7: a running request keeps its operation
    a_r7_op_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(r_q.op) && $stable(r_q.wbit)));

endmodule

// File: tb/owm_slot_master_test.sv
module owm_slot_master_test;
    localparam int CLK_PERIOD = 10;
    localparam int C     = 2;
    localparam int SPU_W = 16;
    localparam int BIT_END_US = 67;
    localparam int RST_END_US = 960;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'b00;
    logic req_bit = 1'b0;
    logic [SPU_W-1:0] req_spu_us = '0;
    logic line_in;
    logic line_drive_n, spu_en, busy, done, result;

    int total = 0;
    int bad = 0;
    int wd_cnt = 0;

    // bench model of a responding device
    logic [1:0] cur_op = 2'b00;
    logic slave_bit = 1'b1;
    logic slave_present = 1'b1;
    logic prev_drv = 1'b1;
    int fall_cnt = 100000;
    int rise_cnt = 100000;
    logic slave_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        prev_drv <= line_drive_n;
        fall_cnt <= (prev_drv && !line_drive_n) ? 0 : fall_cnt + 1;
        rise_cnt <= (!prev_drv && line_drive_n) ? 0 : rise_cnt + 1;
    end

    assign slave_n = !(((cur_op[1]) && !slave_bit && fall_cnt < 20*C) ||
                       ((cur_op == 2'b00) && slave_present && line_drive_n &&
                        rise_cnt >= 30*C && rise_cnt < 130*C));
    assign line_in = line_drive_n & slave_n;

    owm_slot_master #(.CLK_PER_US(C), .SPU_W(SPU_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_bit(req_bit), .req_spu_us(req_spu_us), .line_in(line_in),
        .line_drive_n(line_drive_n), .spu_en(spu_en), .busy(busy),
        .done(done), .result(result)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_low(input logic [1:0] op, input logic b);
        if (op == 2'b00) return 480*C;
        if (op == 2'b01 && !b) return 65*C;
        return 6*C;
    endfunction

    function automatic int exp_end(input logic [1:0] op);
        return (op == 2'b00) ? RST_END_US : BIT_END_US;
    endfunction

    function automatic int exp_res(input logic [1:0] op, input logic sb, input logic sp);
        if (op == 2'b00) return int'(sp);
        if (op == 2'b01) return 0;
        return int'(sb);
    endfunction

    int m_busy, m_low, m_spu, m_spu_first, m_done, m_overlap, m_res;

    task automatic run_op(input logic [1:0] op, input logic b, input int spu, input bit inject);
        int k = 0;
        m_busy = 0; m_low = 0; m_spu = 0; m_spu_first = 0; m_done = 0; m_overlap = 0;
        @(negedge clk);
        cur_op = op;
        req_op = op; req_bit = b; req_spu_us = SPU_W'(spu); req_valid = 1'b1;
        while (k < 20000) begin
            @(negedge clk);
            k++;
            if (k == 1) req_valid = 1'b0;
            if (inject && k == 10) begin
                req_valid = 1'b1; req_op = 2'b00; req_bit = ~b; req_spu_us = 16'd5;
            end
            if (inject && k == 11) req_valid = 1'b0;
            if (busy) m_busy++;
            if (!line_drive_n) m_low++;
            if (spu_en) begin
                m_spu++;
                if (m_spu_first == 0) m_spu_first = k;
            end
            if (spu_en && !line_drive_n) m_overlap++;
            if (done) begin
                m_done++;
                m_res = int'(result);
            end
            if (!busy) break;
        end
        if (k >= 20000) check(1'b0, "R6 watchdog per op", k, 0);
    endtask

    task automatic check_op(input logic [1:0] op, input logic b, input int spu,
                            input bit inject, input string tag);
        int e_end = exp_end(op);
        run_op(op, b, spu, inject);
        check(m_low == exp_low(op, b), {tag, " low time"}, m_low, exp_low(op, b));
        check(m_busy == (e_end + spu)*C + 1, {"R6 R9 busy length ", tag}, m_busy, (e_end + spu)*C + 1);
        check(m_done == 1, {"R6 single done ", tag}, m_done, 1);
        check(m_res == exp_res(op, slave_bit, slave_present), {tag, " result"}, m_res,
              exp_res(op, slave_bit, slave_present));
        check(m_spu == spu*C, {"R8 spu length ", tag}, m_spu, spu*C);
        check(m_overlap == 0, {"R8 no pull during spu ", tag}, m_overlap, 0);
        if (spu > 0)
            check(m_spu_first == e_end*C + 1, {"R8 spu start ", tag}, m_spu_first, e_end*C + 1);
    endtask

    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt > 190000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", wd_cnt, 190000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 0 && done == 0, "R1 busy/done at reset", int'({busy, done}), 0);
        check(line_drive_n == 1 && spu_en == 0, "R1 line/spu at reset",
              int'({line_drive_n, spu_en}), 2);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(busy == 0 && line_drive_n == 1, "R1 idle after release",
              int'({busy, line_drive_n}), 1);

        slave_present = 1'b1;
        check_op(2'b00, 1'b0, 0, 1'b0, "R2 reset with presence");
        slave_present = 1'b0;
        check_op(2'b00, 1'b0, 0, 1'b0, "R2 reset without presence");
        slave_present = 1'b1;
        check_op(2'b01, 1'b1, 0, 1'b0, "R3 write-1");
        check_op(2'b01, 1'b0, 0, 1'b0, "R4 write-0");
        slave_bit = 1'b0;
        check_op(2'b10, 1'b0, 0, 1'b0, "R5 read zero");
        slave_bit = 1'b1;
        check_op(2'b10, 1'b0, 0, 1'b0, "R5 read one");
        slave_bit = 1'b0;
        check_op(2'b11, 1'b0, 0, 1'b0, "R5 read alt code");
        check_op(2'b01, 1'b0, 0, 1'b1, "R7 write-0 ignores request");
        check_op(2'b10, 1'b0, 0, 1'b1, "R7 read ignores request");
        check_op(2'b01, 1'b1, 10, 1'b0, "R8 write-1 with pullup");
        check_op(2'b01, 1'b0, 1, 1'b0, "R8 one-us pullup");

        for (int i = 0; i < 24; i++) begin
            logic [1:0] op = ($urandom % 2 == 0) ? 2'b01 : 2'b10;
            logic b = 1'($urandom % 2);
            int spu = ($urandom % 3 == 0) ? int'($urandom % 13) : 0;
            slave_bit = 1'($urandom % 2);
            check_op(op, b, spu, 1'($urandom % 4 == 0), "R9 random slot");
        end
        check_op(2'b00, 1'b0, 4, 1'b0, "R2 reset with pullup");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule